// File: doc/BRIEF.md
# Packetised Configuration Image Loader

This block fetches a configuration image from a 32-bit parallel NOR flash and hands it, one word at a time, to an FPGA parallel configuration port. The flash data path is made of two 16-bit devices that share their address lines. After reset the loader first reads an options table at flash address zero. The table gives a start byte address for each image page. A page-select input picks one of those pages.

The image in a page is a chain of packets. Each packet starts with a header word that holds a version byte and a payload length in bytes. The loader checks every header. It forwards exactly the payload words that the length covers and then expects the next header. A header with the end marker in its length field finishes the load. An erased header, a wrong version, a zero length or an absent page stops the load with an error code.

Flash reads use a request/acknowledge pair, so any read latency is supported. The payload output uses a valid/ready handshake, and the loader does not fetch the next word until the current one has been accepted.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset, the first flash read is the options word at word address equal to `page_sel`. `page_sel` is held stable for the whole load.
- R2: If the options word for the selected page is all ones, the page is absent. The load stops with `err` set, `err_code` = 1, and no payload.
- R3: An options word gives the page start as a byte address. The first header is read from word address = options word bits [FL_AW+1:2].
- R4: A header word that reads all ones (0xFFFF in both 16-bit halves) is erased data. It stops the load with `err_code` = 2 and is never treated as payload.
- R5: The header version is bits [7:0] and must equal 0x04. Any other value stops the load with `err_code` = 3. This check applies to every header in the chain.
- R6: The header length is bits [31:16], in bytes. A length of 0 stops the load with `err_code` = 4.
- R7: A valid header with length L forwards ceil(L/4) words, in order, from the word addresses that directly follow the header. The word after them is read as the next header, whatever its payload contents are.
- R8: A header whose length is 0xFFFF (with version 0x04) sets `done`. After that the block makes no further flash requests and presents no payload until reset.
- R9: `pl_valid` stays high and `pl_data` stays stable until `pl_ready` is seen. No flash request is made while a payload word is waiting.
- R10: `fl_req` stays high and `fl_addr` stays stable until `fl_ack`, for any number of wait cycles.
- R11: In reset and just after it, `pl_valid`, `done` and `err` are low and `err_code` is 0. `done` and `err` are never high together, and each stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_sel | input | PAGE_W | Selected image page (index into the options table) |
| fl_req | output | 1 | Flash read request |
| fl_addr | output | FL_AW | Flash 32-bit word address |
| fl_ack | input | 1 | Flash read acknowledge; `fl_data` is valid in this cycle |
| fl_data | input | 32 | Flash read data (two 16-bit devices side by side) |
| pl_valid | output | 1 | Payload word available |
| pl_data | output | 32 | Payload word |
| pl_ready | input | 1 | Configuration port accepts the payload word |
| done | output | 1 | Image completed at an end-marker header |
| err | output | 1 | Load aborted |
| err_code | output | 3 | 0 none, 1 absent page, 2 erased header, 3 bad version, 4 zero length |

## Verification
The bench targets the following corner cases.

- An absent page and an erased header location. A loader that skipped these checks would stream 0xFFFFFFFF words as if they were a raw bitstream.
- A wrong version in the second header rather than the first. A design that validated only the first header would keep forwarding after the bad header.
- Lengths that are not a multiple of four. Payload words that are all ones, or that look like a valid header. A byte-to-word rounding slip, or a design that scans for headers instead of counting, would drop, add or misplace words.
- Long stalls on the ready side and varying flash latency. These expose a word changing or being fetched early while the previous one still waits, and an address that moves before its read is acknowledged.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int DATA_W = 32;
    localparam int LEN_W  = 16;

    localparam logic [7:0]       HDR_VERSION = 8'h04;
    localparam logic [LEN_W-1:0] LEN_END     = '1;

    typedef enum logic [2:0] {
        ST_OPT,
        ST_HDR,
        ST_PL,
        ST_OUT,
        ST_DONE,
        ST_FAIL
    } ld_state_e;

    typedef enum logic [2:0] {
        EC_NONE    = 3'd0,
        EC_ABSENT  = 3'd1,
        EC_ERASED  = 3'd2,
        EC_BADVER  = 3'd3,
        EC_ZEROLEN = 3'd4
    } ld_err_e;

    typedef enum logic [1:0] {
        HV_PAYLOAD,
        HV_END,
        HV_FAIL
    } hdr_verdict_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [7:0]       spare;
        logic [7:0]       version;
    } pkt_hdr_t;

    // Byte length rounded up to whole 32-bit words.
    function automatic logic [LEN_W-1:0] bytes_to_words(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] sum;
        sum = {1'b0, len} + (LEN_W+1)'(3);
        return LEN_W'(sum >> 2);
    endfunction

endpackage

// File: rtl/cfgl_hdr_decode.sv
module cfgl_hdr_decode
    import cfgl_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    output hdr_verdict_e      verdict,
    output ld_err_e           fail_code,
    output logic [LEN_W-1:0]  n_words
);
    pkt_hdr_t hdr;

    assign hdr     = pkt_hdr_t'(word);
    assign n_words = bytes_to_words(hdr.len);

    always_comb begin
        verdict   = HV_FAIL;
        fail_code = EC_NONE;
        if (&word) begin
            fail_code = EC_ERASED;
        end else if (hdr.version != HDR_VERSION) begin
            fail_code = EC_BADVER;
        end else if (hdr.len == LEN_END) begin
            verdict = HV_END;
        end else if (hdr.len == '0) begin
            fail_code = EC_ZEROLEN;
        end else begin
            verdict = HV_PAYLOAD;
        end
    end

endmodule

// File: rtl/cfgl_word_counter.sv
module cfgl_word_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/cfgl_out_hold.sv
module cfgl_out_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout,
    output logic         fire
);
    logic         valid_q;
    logic [W-1:0] data_q;

    assign fire  = valid_q && ready;
    assign valid = valid_q;
    assign dout  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            data_q  <= din;
        end else if (fire) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
    import cfgl_pkg::*;
#(
    parameter int FL_AW  = 24,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] page_sel,
    output logic              fl_req,
    output logic [FL_AW-1:0]  fl_addr,
    input  logic              fl_ack,
    input  logic [DATA_W-1:0] fl_data,
    output logic              pl_valid,
    output logic [DATA_W-1:0] pl_data,
    input  logic              pl_ready,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_code
);
    ld_state_e        st_q, st_d;
    logic [FL_AW-1:0] addr_q;
    ld_err_e          code_q;

    hdr_verdict_e     hv;
    ld_err_e          hcode;
    logic [LEN_W-1:0] hwords;

    logic take, fire, cnt_zero, page_absent;
    logic [FL_AW-1:0] page_start;

    assign fl_req      = (st_q == ST_OPT) || (st_q == ST_HDR) || (st_q == ST_PL);
    assign fl_addr     = (st_q == ST_OPT) ? FL_AW'(page_sel) : addr_q;
    assign take        = fl_req && fl_ack;
    assign page_absent = &fl_data;
    assign page_start  = fl_data[FL_AW+1:2];

    cfgl_hdr_decode u_dec (
        .word      (fl_data),
        .verdict   (hv),
        .fail_code (hcode),
        .n_words   (hwords)
    );

    cfgl_word_counter #(.W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     ((st_q == ST_HDR) && take && (hv == HV_PAYLOAD)),
        .load_val (hwords),
        .dec      ((st_q == ST_PL) && take),
        .zero     (cnt_zero)
    );

    cfgl_out_hold #(.W(DATA_W)) u_out (
        .clk   (clk),
        .rst   (rst),
        .load  ((st_q == ST_PL) && take),
        .din   (fl_data),
        .ready (pl_ready),
        .valid (pl_valid),
        .dout  (pl_data),
        .fire  (fire)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OPT: if (take) st_d = page_absent ? ST_FAIL : ST_HDR;
            ST_HDR: if (take) begin
                unique case (hv)
                    HV_PAYLOAD: st_d = ST_PL;
                    HV_END:     st_d = ST_DONE;
                    default:    st_d = ST_FAIL;
                endcase
            end
            ST_PL:  if (take) st_d = ST_OUT;
            ST_OUT: if (fire) st_d = cnt_zero ? ST_HDR : ST_PL;
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_OPT;
            addr_q <= '0;
            code_q <= EC_NONE;
        end else begin
            st_q <= st_d;
            if ((st_q == ST_OPT) && take) begin
                if (page_absent) code_q <= EC_ABSENT;
                else             addr_q <= page_start;
            end
            if ((st_q == ST_HDR) && take) begin
                if (hv == HV_FAIL)        code_q <= hcode;
                else if (hv == HV_PAYLOAD) addr_q <= addr_q + FL_AW'(1);
            end
            if (fire) addr_q <= addr_q + FL_AW'(1);
        end
    end

    assign done     = (st_q == ST_DONE);
    assign err      = (st_q == ST_FAIL);
    assign err_code = code_q;

endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
    parameter int FL_AW = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             fl_req,
    input logic [FL_AW-1:0] fl_addr,
    input logic             fl_ack,
    input logic             pl_valid,
    input logic [31:0]      pl_data,
    input logic             pl_ready,
    input logic             done,
    input logic             err,
    input logic [2:0]       err_code
);
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr)));

    a_r9_valid_hold: assert property (@(posedge clk) disable iff (rst)
        (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data)));

    a_r9_no_fetch_while_waiting: assert property (@(posedge clk) disable iff (rst)
        pl_valid |-> !fl_req);

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!fl_req && !pl_valid));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> (err && $stable(err_code)));

    a_r2_err_has_code: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (err_code != 3'd0));

endmodule

bind cfg_image_loader cfgl_checker #(.FL_AW(FL_AW)) u_cfgl_chk (
    .clk      (clk),
    .rst      (rst),
    .fl_req   (fl_req),
    .fl_addr  (fl_addr),
    .fl_ack   (fl_ack),
    .pl_valid (pl_valid),
    .pl_data  (pl_data),
    .pl_ready (pl_ready),
    .done     (done),
    .err      (err),
    .err_code (err_code)
);

// File: tb/cfg_image_loader_bench.sv
`timescale 1ns/1ps
module cfg_image_loader_bench;
    localparam int FL_AW  = 24;
    localparam int PAGE_W = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PAGE_W-1:0] page_sel = '0;
    logic              fl_req;
    logic [FL_AW-1:0]  fl_addr;
    logic              fl_ack = 1'b0;
    logic [31:0]       fl_data = '0;
    logic              pl_valid;
    logic [31:0]       pl_data;
    logic              pl_ready = 1'b0;
    logic              done, err;
    logic [2:0]        err_code;

    always #10 clk = ~clk;

    cfg_image_loader #(.FL_AW(FL_AW), .PAGE_W(PAGE_W)) u_cfg_image_loader (
        .clk(clk), .rst(rst), .page_sel(page_sel),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_ack(fl_ack), .fl_data(fl_data),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
        .done(done), .err(err), .err_code(err_code)
    );

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] mem [int];
    logic [31:0] exp_q [$];
    int          exp_code;
    bit          exp_done;
    int          got_words;

    int ready_mode = 0;
    int lat_mode   = 0;
    int lat_ctr    = 0;
    int wait_cnt   = 0;
    int cyc        = 0;
    bit prev_stall = 0;
    logic [31:0] prev_data = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] rd(input int a);
        return mem.exists(a) ? mem[a] : 32'hFFFF_FFFF;
    endfunction

    function automatic int next_lat();
        if (lat_mode == 0) return 0;
        lat_ctr = (lat_ctr + 1) % 4;
        return lat_ctr;
    endfunction

    // Behavioural reference: walks the options table and packet chain.
    task automatic build_expect(input int sel);
        logic [31:0] o, h;
        int a, n;
        exp_q.delete();
        exp_code = 0;
        exp_done = 0;
        o = rd(sel);
        if (o == 32'hFFFF_FFFF) begin exp_code = 1; return; end
        a = int'(o >> 2);
        for (int g = 0; g < 64; g++) begin
            h = rd(a);
            if (h == 32'hFFFF_FFFF) begin exp_code = 2; return; end
            if (h[7:0] != 8'h04)    begin exp_code = 3; return; end
            if (h[31:16] == 16'hFFFF) begin exp_done = 1; return; end
            if (h[31:16] == 16'h0)  begin exp_code = 4; return; end
            n = (int'(h[31:16]) + 3) / 4;
            for (int k = 1; k <= n; k++) exp_q.push_back(rd(a + k));
            a = a + n + 1;
        end
    endtask

    task automatic set_options();
        mem.delete();
        mem[0] = 32'hFFFF_FFFF;
        mem[1] = 32'h0004_0000;
        mem[2] = 32'h0214_0000;
        mem[3] = 32'h0008_0000;
    endtask

    task automatic put_pkt(ref int a, input int len, input int ver, input int seed);
        int n;
        mem[a] = {len[15:0], 8'h5A, ver[7:0]};
        n = (len + 3) / 4;
        for (int k = 1; k <= n; k++) mem[a + k] = 32'hC0DE_0000 + 32'(seed * 16 + k);
        a = a + n + 1;
    endtask

    task automatic put_end(input int a);
        mem[a] = 32'hFFFF_0004;
    endtask

    // Flash model, ready driver and per-clock comparisons at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            fl_ack     = 1'b0;
            pl_ready   = 1'b0;
            prev_stall = 0;
            wait_cnt   = 0;
        end else begin
            if (prev_stall)
                check(pl_valid && pl_data == prev_data, "R9", "held word",
                      pl_data, prev_data);
            if (pl_valid && fl_req)
                check(0, "R9", "fetch while word waits", 32'(fl_req), 32'h0);
            if (done && (fl_req || pl_valid))
                check(0, "R8", "activity after done", {fl_req, pl_valid}, 32'h0);
            if (fl_ack) begin
                fl_ack   = 1'b0;
                wait_cnt = next_lat();
            end else if (fl_req) begin
                if (wait_cnt == 0) begin
                    fl_ack  = 1'b1;
                    fl_data = rd(int'(fl_addr));
                end else begin
                    wait_cnt--;
                end
            end
            case (ready_mode)
                0: pl_ready = 1'b1;
                1: pl_ready = (cyc % 3) != 0;
                default: pl_ready = (cyc % 9) == 0;
            endcase
            if (pl_valid && pl_ready) begin
                got_words++;
                if (exp_q.size() == 0)
                    check(0, "R7", "unexpected payload word", pl_data, 32'h0);
                else
                    check(pl_data == exp_q[0], "R7", "payload word (R3 start)",
                          pl_data, exp_q[0]);
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
            prev_stall = pl_valid && !pl_ready;
            prev_data  = pl_data;
        end
    end

    task automatic run_case(input string name, input int sel, input int rmode,
                            input int lmode, input string req);
        int n, total;
        build_expect(sel);
        total      = exp_q.size();
        got_words  = 0;
        ready_mode = rmode;
        lat_mode   = lmode;
        page_sel   = PAGE_W'(sel);
        rst        = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!pl_valid && !done && !err && err_code == 3'd0, "R11",
              {name, " reset state"}, {pl_valid, done, err, err_code}, 32'h0);
        check(fl_addr == FL_AW'(sel), "R1", {name, " options address"},
              32'(fl_addr), 32'(sel));
        rst = 1'b0;
        n = 0;
        while (!(done || err) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (25) @(negedge clk);
        check(32'(err_code) == 32'(exp_code), req, {name, " error code"},
              32'(err_code), 32'(exp_code));
        check(done == exp_done && err == (exp_code != 0), req, {name, " done/err"},
              {done, err}, {exp_done, exp_code != 0});
        check(got_words == total, "R7", {name, " word count"},
              32'(got_words), 32'(total));
        check(!(done && err), "R11", {name, " exclusive status"}, {done, err}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int a;
        // Page 1: lengths 8 and 6 (rounded up to 2 words), then end marker.
        set_options();
        a = 32'h0004_0000 >> 2;
        put_pkt(a, 8, 4, 1);
        put_pkt(a, 6, 4, 2);
        put_end(a);
        mem[(32'h0004_0000 >> 2) + 1] = 32'h0010_0004;
        run_case("two packets", 1, 0, 0, "R8");
        run_case("varied latency", 1, 1, 1, "R10");
        run_case("long stalls", 1, 2, 1, "R9");

        // Page 2: one byte and four bytes, payload of all ones, then end.
        set_options();
        a = 32'h0214_0000 >> 2;
        put_pkt(a, 1, 4, 3);
        put_pkt(a, 4, 4, 4);
        mem[a - 1] = 32'hFFFF_FFFF;
        put_end(a);
        run_case("page two", 2, 1, 1, "R8");

        set_options();
        run_case("absent page", 0, 0, 0, "R2");
        run_case("erased header", 3, 0, 1, "R4");

        // Second header carries version 5.
        set_options();
        a = 32'h0004_0000 >> 2;
        put_pkt(a, 8, 4, 5);
        put_pkt(a, 4, 5, 6);
        put_end(a);
        run_case("bad version", 1, 1, 0, "R5");

        set_options();
        a = 32'h0004_0000 >> 2;
        put_pkt(a, 12, 4, 7);
        mem[a] = 32'h0000_5A04;
        run_case("zero length", 1, 0, 1, "R6");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule